// File: doc/BRIEF.md
# Trapping Integer Adder-Subtractor

This unit is the add/subtract stage of an integer pipeline. One shared adder handles both directions. Subtraction inverts the second operand and forces the adder's carry-in high. Each operation is either trapping or non-trapping. A trapping operation whose signed result does not fit in the data width does not commit its result: the write-enable is withheld and a one-cycle exception request is raised in its place. Non-trapping operations always commit, whatever the overflow or carry outcome.

Operands and the operation code are sampled on a rising clock edge while `opValid` is high. The result, the signed-overflow flag, the carry/borrow flag, the write-enable and the exception request all appear on the registered outputs after that same edge. Vectoring the exception, writing the register file and decoding instructions are done elsewhere.

Top module: `trap_addsub`

## Requirements
- R1: With `opSel` = 2'b00 (trapping add) or 2'b01 (non-trapping add), `result` equals `opA + opB` modulo 2^W.
- R2: With `opSel` = 2'b10 (trapping subtract) or 2'b11 (non-trapping subtract), `result` equals `opA - opB` modulo 2^W. This value is bit-identical to `~(~opA + opB)`.
- R3: `ovfFlag` is high exactly when the two's-complement result of the operation lies outside the signed W-bit range. Operands of differing sign never overflow on add. Operands of equal sign never overflow on subtract.
- R4: For add, `carryFlag` is the carry out of the top bit. For subtract, it is the borrow: high exactly when `opA < opB` as unsigned numbers.
- R5: A trapping operation (`opSel[0]` = 0) that overflows leaves `wrEn` low and drives `excReq` high for one cycle. Example: 0x80000000 + 0xD0000000 traps.
- R6: A non-trapping operation (`opSel[0]` = 1) always gives `wrEn` high and `excReq` low, even when it overflows.
- R7: A carry out of the top bit without signed overflow does not trap. Example: 0xFFFFFFFF + 0x00000002 gives 0x00000001, with `wrEn` high and `excReq` low.
- R8: All outputs are registered and reflect the operation sampled on the previous rising edge. A cycle with `opValid` low gives `wrEn` and `excReq` low on the following cycle.
- R9: A synchronous active-high `rst` clears `result`, `ovfFlag`, `carryFlag`, `wrEn` and `excReq` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | 00 add trap, 01 add no-trap, 10 sub trap, 11 sub no-trap |
| opA | input | W | First operand (minuend for subtract) |
| opB | input | W | Second operand (subtrahend for subtract) |
| result | output | W | Registered sum or difference |
| ovfFlag | output | 1 | Registered signed-overflow flag |
| carryFlag | output | 1 | Registered carry (add) or borrow (subtract) |
| wrEn | output | 1 | Registered destination write-enable |
| excReq | output | 1 | Registered one-cycle exception request |

## Verification
Every output of this unit is due exactly one rising edge after the edge that samples `opValid`, `opSel` and the operands. There is no multi-cycle path, and the trap decision is made in the same cycle as the result.

The bench drives each operation on a falling edge and compares all five outputs on the next falling edge. That compare point falls after the single register stage and before the next operation is applied.

Expected values come from a 64-bit signed and 33-bit unsigned model of each operation. For subtraction, the model's result is also cross-checked against the complement form `~(~a + b)`.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADDU = 2'b01,
    OP_SUB  = 2'b10,
    OP_SUBU = 2'b11
  } arithOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic borrowMode;
    logic trapEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [1:0]  opSel,
  input  logic        ovfRaw,
  output ctrlStrobe_t strobe,
  output logic        wrEn,
  output logic        excReq
);

  arithOp_e opCode;
  logic     trapHit;

  assign opCode = arithOp_e'(opSel);

  always_comb begin
    strobe = '0;
    unique case (opCode)
      OP_ADD:  begin strobe.trapEn = 1'b1; end
      OP_ADDU: begin strobe.trapEn = 1'b0; end
      OP_SUB:  begin
        strobe.trapEn     = 1'b1;
        strobe.invertB    = 1'b1;
        strobe.carryIn    = 1'b1;
        strobe.borrowMode = 1'b1;
      end
      OP_SUBU: begin
        strobe.invertB    = 1'b1;
        strobe.carryIn    = 1'b1;
        strobe.borrowMode = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  assign trapHit = opValid & strobe.trapEn & ovfRaw;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn   <= 1'b0;
      excReq <= 1'b0;
    end else begin
      wrEn   <= opValid & ~trapHit;
      excReq <= trapHit;
    end
  end

endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  ctrlStrobe_t  strobe,
  output logic         ovfRaw,
  output logic [W-1:0] result,
  output logic         ovfFlag,
  output logic         carryFlag
);

  localparam int MSB = W - 1;

  logic [W-1:0] bEff;
  logic [W:0]   sumWide;
  logic [W-1:0] sumNarrow;
  logic         carryOut;
  logic         carryRaw;

  assign bEff      = strobe.invertB ? ~opB : opB;
  assign sumWide   = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, strobe.carryIn};
  assign sumNarrow = sumWide[W-1:0];
  assign carryOut  = sumWide[W];

  // overflow only when adder inputs agree in sign and the sum disagrees
  assign ovfRaw   = (opA[MSB] == bEff[MSB]) && (sumNarrow[MSB] != opA[MSB]);
  assign carryRaw = strobe.borrowMode ? ~carryOut : carryOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      ovfFlag   <= 1'b0;
      carryFlag <= 1'b0;
    end else begin
      result    <= sumNarrow;
      ovfFlag   <= ovfRaw;
      carryFlag <= carryRaw;
    end
  end

endmodule

// File: rtl/trap_addsub.sv
module trap_addsub
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opValid,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         ovfFlag,
  output logic         carryFlag,
  output logic         wrEn,
  output logic         excReq
);

  ctrlStrobe_t strobe;
  logic        ovfRaw;

  addsub_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opValid (opValid),
    .opSel   (opSel),
    .ovfRaw  (ovfRaw),
    .strobe  (strobe),
    .wrEn    (wrEn),
    .excReq  (excReq)
  );

  addsub_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .opA       (opA),
    .opB       (opB),
    .strobe    (strobe),
    .ovfRaw    (ovfRaw),
    .result    (result),
    .ovfFlag   (ovfFlag),
    .carryFlag (carryFlag)
  );

endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         opValid,
  input logic [1:0]   opSel,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] result,
  input logic         ovfFlag,
  input logic         carryFlag,
  input logic         wrEn,
  input logic         excReq
);

  // R1: add result one cycle later
  assert_add_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (opValid && !opSel[1]) |=> (result == $past(opA) + $past(opB)));

  // R3: differing-sign add never overflows
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (opValid && !opSel[1] && (opA[W-1] != opB[W-1])) |=> !ovfFlag);

  // R2/R4: x - x is zero with no borrow and no overflow
  assert_self_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (opValid && opSel[1] && (opA == opB)) |=> (result == '0 && !carryFlag && !ovfFlag));

  // R5: a trap never commits and always has overflow behind it
  assert_trap_blocks_write_R5: assert property (@(posedge clk) disable iff (rst)
    excReq |-> (!wrEn && ovfFlag));

  // R6: non-trapping ops always commit
  assert_untrapped_commit_R6: assert property (@(posedge clk) disable iff (rst)
    (opValid && opSel[0]) |=> (wrEn && !excReq));

  // R8: idle cycle gives no write and no trap
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> (!wrEn && !excReq));

  // R9: reset clears outputs
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result == '0 && !ovfFlag && !carryFlag && !wrEn && !excReq));

endmodule

bind trap_addsub addsub_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opValid   (opValid),
  .opSel     (opSel),
  .opA       (opA),
  .opB       (opB),
  .result    (result),
  .ovfFlag   (ovfFlag),
  .carryFlag (carryFlag),
  .wrEn      (wrEn),
  .excReq    (excReq)
);

// File: tb/sim_trap_addsub.sv
`timescale 1ns/1ps
module sim_trap_addsub;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opValid = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result;
  logic         ovfFlag, carryFlag, wrEn, excReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_addsub #(.W(W)) u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel),
    .opA(opA), .opB(opB), .result(result), .ovfFlag(ovfFlag),
    .carryFlag(carryFlag), .wrEn(wrEn), .excReq(excReq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model: drive at falling edge, compare at next falling edge
  task automatic runOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic valid);
    longint sa, sb, sr;
    logic [W:0] wide;
    logic [W-1:0] expRes, altRes;
    logic expOvf, expCarry, expWr, expExc, trapping;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    trapping = ~op[0];
    if (op[1]) begin
      sr       = sa - sb;
      expRes   = a - b;
      altRes   = ~(~a + b);
      expCarry = (a < b);
      chk("R2 complement cross-check", altRes, expRes);
    end else begin
      sr       = sa + sb;
      wide     = {1'b0, a} + {1'b0, b};
      expRes   = wide[W-1:0];
      expCarry = wide[W];
    end
    expOvf = (sr > 64'sh7FFFFFFF) || (sr < -64'sh80000000);
    expWr  = valid && !(trapping && expOvf);
    expExc = valid && trapping && expOvf;
    opSel = op; opA = a; opB = b; opValid = valid;
    @(negedge clk);
    if (valid) begin
      chk(op[1] ? "R2 result" : "R1 result", result, expRes);
      chk("R3 ovfFlag", {31'b0, ovfFlag}, {31'b0, expOvf});
      chk("R4 carryFlag", {31'b0, carryFlag}, {31'b0, expCarry});
    end
    chk(trapping ? "R5 wrEn" : "R6 wrEn", {31'b0, wrEn}, {31'b0, expWr});
    chk(valid ? (trapping ? "R5 excReq" : "R6 excReq") : "R8 excReq",
        {31'b0, excReq}, {31'b0, expExc});
  endtask

  initial begin
    logic [W-1:0] corners [5];
    corners[0] = 32'h7FFFFFFF; corners[1] = 32'h80000000; corners[2] = 32'hFFFFFFFF;
    corners[3] = 32'h00000000; corners[4] = 32'h00000001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: state after reset
    chk("R9 result reset", result, '0);
    chk("R9 wrEn reset", {31'b0, wrEn}, 32'd0);
    chk("R9 excReq reset", {31'b0, excReq}, 32'd0);

    // R5: two large negatives overflow and trap
    runOp(2'b00, 32'h80000000, 32'hD0000000, 1'b1);
    chk("R5 named trap case", {31'b0, excReq}, 32'd1);
    // R7: unsigned carry without signed overflow
    runOp(2'b00, 32'hFFFFFFFF, 32'h00000002, 1'b1);
    chk("R7 result", result, 32'h00000001);
    chk("R7 carry set no trap", {29'b0, carryFlag, wrEn, excReq}, 32'd6);
    // R6: the same overflowing add, non-trapping
    runOp(2'b01, 32'h80000000, 32'hD0000000, 1'b1);
    // R8: idle cycle after a trap
    runOp(2'b00, 32'h7FFFFFFF, 32'h00000001, 1'b1);
    runOp(2'b00, 32'h7FFFFFFF, 32'h00000001, 1'b0);

    // corner sweep over all ops and pairings
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          runOp(op[1:0], corners[i], corners[j], 1'b1);

    // R9: reset in the middle of traffic
    opSel = 2'b01; opA = 32'hFFFFFFFF; opB = 32'hFFFFFFFF; opValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; opValid = 1'b0;
    chk("R9 mid-run result", result, '0);
    chk("R9 mid-run flags", {29'b0, ovfFlag, carryFlag, wrEn}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule